// File: doc/BRIEF.md
# Programmable Counter-Timer Channel

A single timer channel with three registers on a small word-wide register port: a running count, a mode/status word and a compare target. The counter width is a parameter (16 bits for a small channel, 32 bits for a large one). Each count step comes from the system clock or from rising edges of an external tick input. The step can pass through a prescaler and can be held off by a gate input.

The channel raises a compare event when a count step lands on the target and an overflow event when the counter wraps from all-ones to zero. Each event sets a sticky flag that software can read. It produces a one-cycle interrupt pulse when its enable bit and an internal armed bit are both set. The armed bit gives one-shot, repeating or alternating interrupt behaviour. Accesses to the mode word have side effects: a write clears the count and re-arms the channel, and a read clears the flags. A target write can also re-arm it.

Top module: `tmr_channel`

## Requirements
- R1: Writing address 0 loads the counter with the low counter-width bits of the write data. Reading address 0 returns the count, zero-extended to the bus width.
- R2: With mode bit 8 clear, prescaler code 0 and mode bit 0 clear, the counter advances by one on every clock in which no register is written.
- R3: With mode bit 8 set, the counter advances once per rising edge of ext_tick, two clocks after the edge is sampled, however long the input stays high.
- R4: With mode bit 0 set, the counter advances only in cycles where gate_in is high. Mode bits 1-2 are stored and read back with no further effect.
- R5: The prescaler code selects one step per 1, 8, 16 or 256 source ticks for codes 0, 1, 2 and 3. With PRESC_STYLE 2 the code is mode bits 13-14. With PRESC_STYLE 1 it is mode bit 9 (0 selects /1, 1 selects /8). With PRESC_STYLE 0 it is always /1.
- R6: A step that makes the count equal the target sets the compare flag (mode bit 11) whatever the enables are. It drives irq_o high for the next cycle only when mode bit 4 and the armed bit (mode bit 10) are both 1.
- R7: A step from all-ones to zero sets the overflow flag (mode bit 12). It pulses irq_o when mode bit 5 and the armed bit are both 1.
- R8: With mode bit 3 set, the step that reaches the target loads zero instead, so the count repeats every target steps.
- R9: On an enabled event, the armed bit clears after an interrupt when mode bit 6 is clear. It inverts when bits 6 and 7 are both set, so interrupts fall on alternate events. Otherwise it stays set.
- R10: Reset leaves all mode fields, flags, count and target at zero and the armed bit at 1. A mode write clears the count and the prescaler phase and sets the armed bit. A mode read strobe clears both flags, unless an event sets a flag in the same cycle.
- R11: A target write sets the armed bit when mode bit 7 is clear and leaves it unchanged when bit 7 is set.
- R12: A register write to any of addresses 0-2 blocks the count step of that cycle, so a count write is never lost to an increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Register select: 0 count, 1 mode/status, 2 target |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_rd | input | 1 | Read strobe (side effect on the mode register only) |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data of the selected register, combinational |
| ext_tick | input | 1 | External count source, asynchronous |
| gate_in | input | 1 | Count gate, synchronous to clk |
| irq_o | output | 1 | Interrupt request, one-cycle pulse per interrupt |

## Verification
The assertions treat gate_in and the register strobes as synchronous to clk and stable around the rising edge. Only ext_tick passes through a synchroniser. The read-clear property is only claimed for cycles with no event, because a flag being set that cycle takes priority. The bench changes every input on the falling edge and reads bus_rdata shortly after. It raises at most one strobe per cycle and holds ext_tick high or low for several clocks, so each edge survives synchronisation.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   localparam logic [1:0] SEL_COUNT  = 2'd0;
   localparam logic [1:0] SEL_MODE   = 2'd1;
   localparam logic [1:0] SEL_TARGET = 2'd2;

   localparam int B_GATE_EN = 0;
   localparam int B_GATE_LO = 1;
   localparam int B_ZRET    = 3;
   localparam int B_CMP_EN  = 4;
   localparam int B_OVF_EN  = 5;
   localparam int B_RPT     = 6;
   localparam int B_TOG     = 7;
   localparam int B_EXT     = 8;
   localparam int B_PRE1    = 9;
   localparam int B_ARMED   = 10;
   localparam int B_CMPF    = 11;
   localparam int B_OVFF    = 12;
   localparam int B_PRE2_LO = 13;
   localparam int MODE_MSB  = 14;

   typedef struct packed {
      logic [1:0] presc;
      logic       ext_sel;
      logic       tog;
      logic       rpt;
      logic       ovf_en;
      logic       cmp_en;
      logic       zret;
      logic [1:0] gate_md;
      logic       gate_en;
   } mode_t;

endpackage

// File: rtl/tmr_tick_sync.sv
module tmr_tick_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_in,
   output logic pulse_o
);

   logic [STAGES-1:0] sr;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '0;
         prev <= 1'b0;
      end else begin
         sr   <= {sr[STAGES-2:0], tick_in};
         prev <= sr[STAGES-1];
      end
   end

   assign pulse_o = sr[STAGES-1] & ~prev;

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int STYLE = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       src_tick,
   input  logic [1:0] code,
   output logic       tick_o
);

   localparam int PRE_W = 8;

   generate
      if (STYLE == 0) begin : g_none
         logic unused_pre;
         assign unused_pre = ^{clk, rst_n, clr, code};
         assign tick_o     = src_tick;
      end else begin : g_div
         logic [PRE_W-1:0] pc;
         logic [PRE_W-1:0] last;
         logic             wrap;

         always_comb begin
            case (code)
               2'd0:    last = '0;
               2'd1:    last = PRE_W'(7);
               2'd2:    last = PRE_W'(15);
               default: last = PRE_W'(255);
            endcase
         end

         assign wrap   = (pc == last);
         assign tick_o = src_tick & wrap;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pc <= '0;
            else if (clr)
               pc <= '0;
            else if (src_tick)
               pc <= wrap ? '0 : pc + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic cmp_evt,
   input  logic ovf_evt,
   input  logic cmp_en,
   input  logic ovf_en,
   input  logic rpt,
   input  logic tog,
   input  logic arm_set,
   input  logic flag_clr,
   output logic armed,
   output logic cmp_flag,
   output logic ovf_flag,
   output logic fire,
   output logic irq_o
);

   logic en_evt;
   logic armed_d;

   assign en_evt = (cmp_evt & cmp_en) | (ovf_evt & ovf_en);
   assign fire   = en_evt & armed;

   always_comb begin
      armed_d = armed;
      if (arm_set)
         armed_d = 1'b1;
      else if (en_evt) begin
         if (!rpt)
            armed_d = armed & ~fire;
         else if (tog)
            armed_d = ~armed;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed    <= 1'b1;
         cmp_flag <= 1'b0;
         ovf_flag <= 1'b0;
         irq_o    <= 1'b0;
      end else begin
         armed    <= armed_d;
         cmp_flag <= cmp_evt | (cmp_flag & ~flag_clr);
         ovf_flag <= ovf_evt | (ovf_flag & ~flag_clr);
         irq_o    <= fire;
      end
   end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int BUS_W       = 32,
   parameter int PRESC_STYLE = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       bus_sel,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   input  logic             ext_tick,
   input  logic             gate_in,
   output logic             irq_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   initial begin : p_param_chk
      assert (CNT_W >= 2 && CNT_W <= BUS_W)
         else $fatal(1, "tmr_channel: CNT_W must lie in 2..BUS_W");
      assert (BUS_W > MODE_MSB)
         else $fatal(1, "tmr_channel: BUS_W too narrow for the mode word");
      assert (PRESC_STYLE >= 0 && PRESC_STYLE <= 2)
         else $fatal(1, "tmr_channel: PRESC_STYLE must be 0, 1 or 2");
      assert (SYNC_STAGES >= 2)
         else $fatal(1, "tmr_channel: SYNC_STAGES must be at least 2");
   end

   // register access decode
   logic wr_cnt, wr_mode, wr_tgt, reg_wr, rd_mode;
   assign wr_cnt  = bus_wr && (bus_sel == SEL_COUNT);
   assign wr_mode = bus_wr && (bus_sel == SEL_MODE);
   assign wr_tgt  = bus_wr && (bus_sel == SEL_TARGET);
   assign reg_wr  = wr_cnt | wr_mode | wr_tgt;
   assign rd_mode = bus_rd && (bus_sel == SEL_MODE);

   // mode and target registers
   mode_t            mode_q;
   mode_t            mode_wval;
   logic [1:0]       wr_presc;
   logic [CNT_W-1:0] tgt_q;

   generate
      if (PRESC_STYLE == 2) begin : g_pw2
         assign wr_presc = bus_wdata[B_PRE2_LO +: 2];
      end else if (PRESC_STYLE == 1) begin : g_pw1
         assign wr_presc = {1'b0, bus_wdata[B_PRE1]};
      end else begin : g_pw0
         assign wr_presc = 2'b00;
      end
   endgenerate

   always_comb begin
      mode_wval         = '0;
      mode_wval.gate_en = bus_wdata[B_GATE_EN];
      mode_wval.gate_md = bus_wdata[B_GATE_LO +: 2];
      mode_wval.zret    = bus_wdata[B_ZRET];
      mode_wval.cmp_en  = bus_wdata[B_CMP_EN];
      mode_wval.ovf_en  = bus_wdata[B_OVF_EN];
      mode_wval.rpt     = bus_wdata[B_RPT];
      mode_wval.tog     = bus_wdata[B_TOG];
      mode_wval.ext_sel = bus_wdata[B_EXT];
      mode_wval.presc   = wr_presc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         tgt_q  <= '0;
      end else begin
         if (wr_mode) mode_q <= mode_wval;
         if (wr_tgt)  tgt_q  <= bus_wdata[CNT_W-1:0];
      end
   end

   // count source: external edge or system clock, gated, then prescaled
   logic ext_pulse, src_raw, gate_ok, src_tick, inc;

   tmr_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_in (ext_tick),
      .pulse_o (ext_pulse)
   );

   assign src_raw  = mode_q.ext_sel ? ext_pulse : 1'b1;
   assign gate_ok  = ~mode_q.gate_en | gate_in;
   assign src_tick = src_raw & gate_ok & ~reg_wr;

   tmr_prescale #(.STYLE(PRESC_STYLE)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (wr_mode),
      .src_tick (src_tick),
      .code     (mode_q.presc),
      .tick_o   (inc)
   );

   // counter and event detection
   logic [CNT_W-1:0] cnt_q, cnt_d, cnt_plus;
   logic             cmp_evt, ovf_evt;

   assign cnt_plus = cnt_q + 1'b1;
   assign cmp_evt  = inc && (cnt_plus == tgt_q);
   assign ovf_evt  = inc && (cnt_q == CNT_MAX);

   always_comb begin
      cnt_d = cnt_q;
      if (wr_mode)
         cnt_d = '0;
      else if (wr_cnt)
         cnt_d = bus_wdata[CNT_W-1:0];
      else if (inc)
         cnt_d = (cmp_evt && mode_q.zret) ? '0 : cnt_plus;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   // interrupt control
   logic armed, cmp_flag, ovf_flag, fire, arm_set;
   assign arm_set = wr_mode | (wr_tgt & ~mode_q.tog);

   tmr_irq_ctl u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmp_evt  (cmp_evt),
      .ovf_evt  (ovf_evt),
      .cmp_en   (mode_q.cmp_en),
      .ovf_en   (mode_q.ovf_en),
      .rpt      (mode_q.rpt),
      .tog      (mode_q.tog),
      .arm_set  (arm_set),
      .flag_clr (rd_mode),
      .armed    (armed),
      .cmp_flag (cmp_flag),
      .ovf_flag (ovf_flag),
      .fire     (fire),
      .irq_o    (irq_o)
   );

   // read-back
   logic [BUS_W-1:0] presc_rd, mode_rd;

   generate
      if (PRESC_STYLE == 2) begin : g_pr2
         assign presc_rd = BUS_W'(mode_q.presc) << B_PRE2_LO;
      end else if (PRESC_STYLE == 1) begin : g_pr1
         assign presc_rd = BUS_W'(mode_q.presc[0]) << B_PRE1;
      end else begin : g_pr0
         assign presc_rd = '0;
      end
   endgenerate

   always_comb begin
      mode_rd                    = presc_rd;
      mode_rd[B_GATE_EN]         = mode_q.gate_en;
      mode_rd[B_GATE_LO +: 2]    = mode_q.gate_md;
      mode_rd[B_ZRET]            = mode_q.zret;
      mode_rd[B_CMP_EN]          = mode_q.cmp_en;
      mode_rd[B_OVF_EN]          = mode_q.ovf_en;
      mode_rd[B_RPT]             = mode_q.rpt;
      mode_rd[B_TOG]             = mode_q.tog;
      mode_rd[B_EXT]             = mode_q.ext_sel;
      mode_rd[B_ARMED]           = armed;
      mode_rd[B_CMPF]            = cmp_flag;
      mode_rd[B_OVFF]            = ovf_flag;
   end

   always_comb begin
      case (bus_sel)
         SEL_COUNT:  bus_rdata = BUS_W'(cnt_q);
         SEL_MODE:   bus_rdata = mode_rd;
         SEL_TARGET: bus_rdata = BUS_W'(tgt_q);
         default:    bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       bus_sel,
   input logic             bus_wr,
   input logic             bus_rd,
   input logic [CNT_W-1:0] wdata,
   input logic [CNT_W-1:0] cnt,
   input logic             inc,
   input logic             reg_wr,
   input logic             cmp_evt,
   input logic             ovf_evt,
   input logic             armed,
   input logic             cmp_flag,
   input logic             ovf_flag,
   input logic             fire,
   input logic             rpt,
   input logic             tog,
   input logic             irq_o
);

   AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel == 2'd0) |=> (cnt == $past(wdata)));          // R1

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr && !inc) |=> $stable(cnt));                             // R2

   AST_IRQ_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(armed));                                         // R6

   AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> ovf_flag);                                           // R7

   AST_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !rpt) |=> !armed);                                      // R9

   AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel == 2'd1) |=> (armed && cnt == '0));           // R10

   AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_sel == 2'd1 && !cmp_evt && !ovf_evt)
         |=> (!cmp_flag && !ovf_flag));                                // R10

   AST_TARGET_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel == 2'd2 && !tog) |=> armed);                  // R11

   AST_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> !inc);                                                // R12

endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_sel  (bus_sel),
   .bus_wr   (bus_wr),
   .bus_rd   (bus_rd),
   .wdata    (bus_wdata[CNT_W-1:0]),
   .cnt      (cnt_q),
   .inc      (inc),
   .reg_wr   (reg_wr),
   .cmp_evt  (cmp_evt),
   .ovf_evt  (ovf_evt),
   .armed    (armed),
   .cmp_flag (cmp_flag),
   .ovf_flag (ovf_flag),
   .fire     (fire),
   .rpt      (mode_q.rpt),
   .tog      (mode_q.tog),
   .irq_o    (irq_o)
);

// File: tb/sim_tmr_channel.sv
`timescale 1ns/1ps
module sim_tmr_channel;

   localparam int CW = 16;
   localparam logic [1:0] A_CNT = 2'd0, A_MODE = 2'd1, A_TGT = 2'd2;
   localparam logic [31:0] M_GATE = 32'h1,  M_ZRET = 32'h8,  M_CMP = 32'h10;
   localparam logic [31:0] M_OVF  = 32'h20, M_RPT  = 32'h40, M_TOG = 32'h80;
   localparam logic [31:0] M_EXT  = 32'h100;
   localparam int ARM = 10, CMPF = 11, OVFF = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_sel = 2'd0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        ext_tick = 1'b0;
   logic        gate_in = 1'b0;
   logic        irq_o;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   tmr_channel #(.CNT_W(CW), .BUS_W(32), .PRESC_STYLE(2), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ext_tick(ext_tick), .gate_in(gate_in), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic peek(input logic [1:0] s, output logic [31:0] v);
      bus_sel = s;
      #0.5;
      v = bus_rdata;
   endtask

   task automatic rd_strobe_mode();
      @(negedge clk);
      bus_sel = A_MODE; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic run(input int n, output int pulses, output logic [31:0] mask);
      pulses = 0; mask = '0;
      for (int i = 1; i <= n; i++) begin
         @(negedge clk);
         if (irq_o) begin pulses++; mask[i] = 1'b1; end
      end
   endtask

   task automatic t_reset();
      logic [31:0] v;
      wait_n(3);
      peek(A_CNT, v);  check("R10 reset count", v, 0);
      peek(A_MODE, v); check("R10 reset mode armed only", v, 32'h400);
      peek(A_TGT, v);  check("R10 reset target", v, 0);
      check("R10 reset irq", {31'b0, irq_o}, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_free();
      logic [31:0] v;
      wr(A_MODE, 0);
      peek(A_CNT, v); check("R10 mode write clears count", v, 0);
      wait_n(5);
      peek(A_CNT, v); check("R2 free run five clocks", v, 5);
   endtask

   task automatic t_count_write();
      logic [31:0] v;
      wr(A_CNT, 32'h1234);
      peek(A_CNT, v); check("R12 count write beats increment", v, 32'h1234);
      wait_n(1);
      peek(A_CNT, v); check("R1 counts on from loaded value", v, 32'h1235);
      wr(A_CNT, 32'hABCD_0007);
      peek(A_CNT, v); check("R1 upper bits dropped and read as zero", v, 32'h7);
   endtask

   task automatic t_gate();
      logic [31:0] v;
      gate_in = 1'b0;
      wr(A_MODE, M_GATE | 32'h6);
      wait_n(4);
      peek(A_CNT, v); check("R4 gate low holds count", v, 0);
      peek(A_MODE, v); check("R4 gate mode bits read back", v, 32'h407);
      gate_in = 1'b1;
      wait_n(3);
      peek(A_CNT, v); check("R4 gate high counts", v, 3);
      gate_in = 1'b0;
      wait_n(4);
      peek(A_CNT, v); check("R4 gate low again holds", v, 3);
   endtask

   task automatic t_ext();
      logic [31:0] v;
      ext_tick = 1'b0;
      wr(A_MODE, M_EXT);
      wait_n(3);
      peek(A_CNT, v); check("R3 no edges no count", v, 0);
      for (int i = 0; i < 5; i++) begin
         ext_tick = 1'b1; wait_n(3);
         ext_tick = 1'b0; wait_n(2);
      end
      wait_n(4);
      peek(A_CNT, v); check("R3 one step per rising edge", v, 5);
   endtask

   task automatic t_presc();
      logic [31:0] v;
      wr(A_MODE, 32'd1 << 13);
      wait_n(7);
      peek(A_CNT, v); check("R5 div8 before 8th tick", v, 0);
      wait_n(1);
      peek(A_CNT, v); check("R5 div8 at 8th tick", v, 1);
      wait_n(8);
      peek(A_CNT, v); check("R5 div8 second step", v, 2);
      wr(A_MODE, 32'd2 << 13);
      wait_n(32);
      peek(A_CNT, v); check("R5 div16 after 32 clocks", v, 2);
      wr(A_MODE, 32'd3 << 13);
      peek(A_MODE, v); check("R5 code at bits 13-14", v, (32'd3 << 13) | 32'h400);
      wait_n(255);
      peek(A_CNT, v); check("R5 div256 before 256th tick", v, 0);
      wait_n(1);
      peek(A_CNT, v); check("R5 div256 at 256th tick", v, 1);
   endtask

   task automatic t_compare();
      logic [31:0] v, mask;
      int p;
      wr(A_TGT, 10);
      wr(A_MODE, M_CMP);
      wait_n(9);
      check("R6 no irq before match", {31'b0, irq_o}, 0);
      wait_n(1);
      check("R6 irq on match", {31'b0, irq_o}, 1);
      peek(A_MODE, v); check("R9 one-shot disarms and flag set", v, 32'h810);
      wait_n(1);
      check("R6 irq is one cycle", {31'b0, irq_o}, 0);
      rd_strobe_mode();
      peek(A_MODE, v); check("R10 read strobe clears flag", v[CMPF], 0);
      wr(A_CNT, 5);
      run(8, p, mask);
      check("R9 disarmed channel gives no irq", p, 0);
      peek(A_MODE, v); check("R6 flag set while disarmed", v[CMPF], 1);
      wr(A_TGT, 3);
      wr(A_MODE, 0);
      run(5, p, mask);
      check("R6 compare disabled gives no irq", p, 0);
      peek(A_MODE, v); check("R6 flag set while disabled", v[CMPF], 1);
      rd_strobe_mode();
   endtask

   task automatic t_zret();
      logic [31:0] v;
      wr(A_TGT, 4);
      wr(A_MODE, M_ZRET | M_CMP | M_RPT);
      wait_n(3);
      peek(A_CNT, v); check("R8 count before target", v, 3);
      wait_n(1);
      peek(A_CNT, v); check("R8 returns to zero at target", v, 0);
      check("R8 irq at wrap to zero", {31'b0, irq_o}, 1);
      wait_n(4);
      check("R9 repeat stays armed irq again", {31'b0, irq_o}, 1);
      peek(A_MODE, v); check("R9 repeat armed bit", v[ARM], 1);
   endtask

   task automatic t_toggle();
      logic [31:0] v, mask;
      int p;
      wr(A_TGT, 3);
      wr(A_MODE, M_ZRET | M_CMP | M_RPT | M_TOG);
      run(12, p, mask);
      check("R9 toggle irq on alternate events", mask, (32'd1 << 3) | (32'd1 << 9));
      wr(A_TGT, 2);
      wr(A_MODE, M_CMP | M_RPT | M_TOG);
      wait_n(2);
      peek(A_MODE, v); check("R9 toggle disarms after irq", v[ARM], 0);
      wr(A_TGT, 100);
      peek(A_MODE, v); check("R11 target write no rearm in toggle mode", v[ARM], 0);
      wr(A_TGT, 2);
      wr(A_MODE, M_CMP);
      wait_n(2);
      peek(A_MODE, v); check("R11 disarmed before target write", v[ARM], 0);
      wr(A_TGT, 100);
      peek(A_MODE, v); check("R11 target write rearms", v[ARM], 1);
      rd_strobe_mode();
   endtask

   task automatic t_overflow();
      logic [31:0] v;
      wr(A_TGT, 32'h8000);
      wr(A_MODE, M_OVF | M_RPT);
      wr(A_CNT, 32'hFFFD);
      wait_n(2);
      peek(A_CNT, v); check("R7 count at all-ones", v, 32'hFFFF);
      check("R7 no irq before wrap", {31'b0, irq_o}, 0);
      wait_n(1);
      peek(A_CNT, v); check("R7 wraps to zero", v, 0);
      check("R7 irq on wrap", {31'b0, irq_o}, 1);
      peek(A_MODE, v); check("R7 overflow flag only", v[OVFF:CMPF], 2'b10);
      rd_strobe_mode();
      peek(A_MODE, v); check("R10 read strobe clears overflow flag", v[OVFF], 0);
      wr(A_MODE, M_RPT);
      wr(A_CNT, 32'hFFFE);
      wait_n(2);
      check("R7 overflow disabled no irq", {31'b0, irq_o}, 0);
      peek(A_MODE, v); check("R7 flag set while disabled", v[OVFF], 1);
   endtask

   initial begin : wd
      #1_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      t_reset();
      t_free();
      t_count_write();
      t_gate();
      t_ext();
      t_presc();
      t_compare();
      t_zret();
      t_toggle();
      t_overflow();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule